// File: doc/BRIEF.md
# Clock Source and Stop-Mode Control

This block holds one 8-bit control register and turns its contents into the clock controls of a small chip. It picks whether the system clock is taken from the crystal oscillator or from the PLL. It decides whether the oscillator keeps running while the chip is stopped. It also decides which of the two low-power timers, the periodic interrupt timer and the watchdog, keep their clocks during stop. The PLL, the oscillators and the watchdog counter sit outside this block. Here they are only steered through select, enable and restart outputs.

Software writes the register through a single-cycle write strobe and can read it back at any time. The block follows stop mode from a stop-request pulse and a stop-exit pulse. An oscillator-up flag locks the source select to the PLL whenever the oscillator is not running. The watchdog can run from an internal RC clock. Its stop gating is passed through a short synchronizer that advances on a slow-clock tick, which models the latency of crossing into that clock domain.

Top module: `clkstop_ctl`

## Requirements
- R1: After reset, rd_data reads 0x01 (bit 0 PLL select set, all other bits 0). In that state sys_clk_sel, osc_run, tmr_clk_en and wd_clk_en are 1 and wd_restart is 0.
- R2: A write with wr_data bit 0 = 0 clears the PLL select bit only while osc_up is 1. While osc_up is 0, such a write leaves bit 0 at 1, and the other bits of the write are still taken.
- R3: While osc_up is 0, register bit 0 is 1 from the next clock edge on.
- R4: A stop_req pulse while not in stop, with register bit 1 (pseudo-stop) at 0, sets register bit 0 at the same edge that enters stop.
- R5: sys_clk_sel equals register bit 0: 0 selects the oscillator clock and 1 selects the PLL clock.
- R6: osc_run is 0 while in stop with register bit 1 at 0, and 1 otherwise.
- R7: wd_restart is a one-cycle pulse in the cycle after a write that changes bit 3 (watchdog source high bit), or that changes bit 4 (source low bit) while bit 3 is 0 both before and after the write. A change of bit 4 alone while bit 3 is 1 gives no pulse.
- R8: Bit 3 can be written while osc_up is 0, and it keeps its value when osc_up goes to 0.
- R9: In stop, tmr_clk_en is 1 only when bit 1, bit 5 (timer pseudo-stop enable) and bit 7 (timer oscillator source) are all 1. Outside stop it is 1.
- R10: With bit 3 at 0, wd_clk_en in stop is 1 only when bit 1, bit 6 (watchdog pseudo-stop enable) and bit 4 are all 1. Outside stop it is 1.
- R11: With bit 3 at 1 and bit 2 (watchdog stop gate) at 1, wd_clk_en falls on the SYNC_STAGES-th slow_tick after stop entry. It rises again on the SYNC_STAGES-th slow_tick after stop exit. With bit 2 at 0 it stays 1.
- R12: stop_req enters stop and stop_exit leaves it, each taking effect at the next clock edge. A stop_req pulse while already in stop is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_up | input | 1 | Oscillator-up status flag |
| stop_req | input | 1 | One-cycle request to enter stop |
| stop_exit | input | 1 | One-cycle indication that stop is left |
| slow_tick | input | 1 | One-cycle strobe for each slow RC clock cycle |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Current register contents |
| sys_clk_sel | output | 1 | System clock mux select: 0 oscillator, 1 PLL |
| osc_run | output | 1 | Oscillator enable |
| tmr_clk_en | output | 1 | Clock enable for the periodic timer |
| wd_clk_en | output | 1 | Clock enable for the watchdog |
| wd_restart | output | 1 | Watchdog timeout restart pulse |

## Verification
Register contents, the source select and the stop state all change at the first clock edge after the stimulus. The enables derived from them are combinational, so they are due in that same cycle. The restart pulse is registered at that edge and must be gone one edge later. The watchdog stop gate lags by SYNC_STAGES slow ticks. The bench drives inputs on the falling edge, steps one full clock per stimulus, and samples on the following falling edge. For the synchronizer test it issues ticks one at a time and checks after each tick, so both the edge on which the gate moves and the edge before it are observed.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;

    localparam int CTRL_W = 8;

    // Control register layout, MSB first
    typedef struct packed {
        logic tmr_osc_src;   // bit 7: timer runs from oscillator
        logic wd_ps_en;      // bit 6: watchdog enable in pseudo stop
        logic tmr_ps_en;     // bit 5: timer enable in pseudo stop
        logic wd_src0;       // bit 4: watchdog source, low select
        logic wd_src1;       // bit 3: watchdog source, RC clock
        logic wd_stop_gate;  // bit 2: gate RC watchdog clock in stop
        logic pstop;         // bit 1: oscillator keeps running in stop
        logic pll_sel;       // bit 0: system clock from PLL
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{pll_sel: 1'b1, default: 1'b0};

    // Effective watchdog source changed: high bit toggled, or low bit
    // toggled while the high bit stays clear.
    function automatic logic wd_src_changed(input ctrl_t old_v, input ctrl_t new_v);
        logic hi_diff;
        logic lo_diff;
        hi_diff = old_v.wd_src1 ^ new_v.wd_src1;
        lo_diff = old_v.wd_src0 ^ new_v.wd_src0;
        return hi_diff | (lo_diff & ~old_v.wd_src1 & ~new_v.wd_src1);
    endfunction

endpackage

// File: rtl/clkstop_regs.sv
module clkstop_regs
    import clkstop_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  osc_up,
    input  logic  full_stop_entry,
    input  logic  wr_en,
    input  ctrl_t wr_val,
    output ctrl_t ctrl_q,
    output logic  restart_q
);

    ctrl_t ctrl_nxt;

    always_comb begin
        ctrl_nxt = ctrl_q;
        if (wr_en) begin
            ctrl_nxt = wr_val;
        end
        // PLL select is pinned high without oscillator or on full stop
        if (!osc_up || full_stop_entry) begin
            ctrl_nxt.pll_sel = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= CTRL_RESET;
            restart_q <= 1'b0;
        end else begin
            ctrl_q    <= ctrl_nxt;
            restart_q <= wr_en && wd_src_changed(ctrl_q, wr_val);
        end
    end

endmodule

// File: rtl/clkstop_mode.sv
module clkstop_mode
    import clkstop_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  stop_req,
    input  logic  stop_exit,
    input  logic  slow_tick,
    input  ctrl_t ctrl,
    output logic  in_stop,
    output logic  full_stop_entry,
    output logic  osc_run,
    output logic  tmr_clk_en,
    output logic  wd_clk_en
);

    logic in_stop_q;
    logic gate_req;
    logic gate_sync;
    logic pseudo;

    assign full_stop_entry = stop_req && !in_stop_q && !ctrl.pstop;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_stop_q <= 1'b0;
        end else if (!in_stop_q && stop_req) begin
            in_stop_q <= 1'b1;
        end else if (in_stop_q && stop_exit) begin
            in_stop_q <= 1'b0;
        end
    end

    assign gate_req = in_stop_q && ctrl.wd_stop_gate;

    // Stop gate carried into the slow clock domain
    generate
        if (SYNC_STAGES <= 1) begin : g_sync_one
            logic sh_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    sh_q <= 1'b0;
                end else if (slow_tick) begin
                    sh_q <= gate_req;
                end
            end
            assign gate_sync = sh_q;
        end else begin : g_sync_many
            logic [SYNC_STAGES-1:0] sh_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    sh_q <= '0;
                end else if (slow_tick) begin
                    sh_q <= {sh_q[SYNC_STAGES-2:0], gate_req};
                end
            end
            assign gate_sync = sh_q[SYNC_STAGES-1];
        end
    endgenerate

    assign pseudo     = in_stop_q && ctrl.pstop;
    assign in_stop    = in_stop_q;
    assign osc_run    = !in_stop_q || ctrl.pstop;
    assign tmr_clk_en = !in_stop_q || (pseudo && ctrl.tmr_ps_en && ctrl.tmr_osc_src);

    always_comb begin
        if (ctrl.wd_src1) begin
            wd_clk_en = !gate_sync;
        end else begin
            wd_clk_en = !in_stop_q || (pseudo && ctrl.wd_ps_en && ctrl.wd_src0);
        end
    end

endmodule

// File: rtl/clkstop_ctl.sv
module clkstop_ctl
    import clkstop_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              osc_up,
    input  logic              stop_req,
    input  logic              stop_exit,
    input  logic              slow_tick,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output logic [CTRL_W-1:0] rd_data,
    output logic              sys_clk_sel,
    output logic              osc_run,
    output logic              tmr_clk_en,
    output logic              wd_clk_en,
    output logic              wd_restart
);

    ctrl_t ctrl_q;
    logic  in_stop;
    logic  full_stop_entry;

    clkstop_regs u_regs (
        .clk             (clk),
        .rst             (rst),
        .osc_up          (osc_up),
        .full_stop_entry (full_stop_entry),
        .wr_en           (wr_en),
        .wr_val          (ctrl_t'(wr_data)),
        .ctrl_q          (ctrl_q),
        .restart_q       (wd_restart)
    );

    clkstop_mode #(.SYNC_STAGES(SYNC_STAGES)) u_mode (
        .clk             (clk),
        .rst             (rst),
        .stop_req        (stop_req),
        .stop_exit       (stop_exit),
        .slow_tick       (slow_tick),
        .ctrl            (ctrl_q),
        .in_stop         (in_stop),
        .full_stop_entry (full_stop_entry),
        .osc_run         (osc_run),
        .tmr_clk_en      (tmr_clk_en),
        .wd_clk_en       (wd_clk_en)
    );

    assign rd_data     = CTRL_W'(ctrl_q);
    assign sys_clk_sel = ctrl_q.pll_sel;

endmodule

// File: rtl/clkstop_chk.sv
module clkstop_chk (
    input logic       clk,
    input logic       rst,
    input logic       osc_up,
    input logic       stop_req,
    input logic       wr_en,
    input logic [7:0] rd_data,
    input logic       sys_clk_sel,
    input logic       tmr_clk_en,
    input logic       wd_restart,
    input logic       in_stop
);

    p_clear_needs_osc_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(sys_clk_sel) |-> $past(osc_up) && $past(wr_en));

    p_osc_down_force_r3: assert property (@(posedge clk) disable iff (rst)
        !osc_up |=> sys_clk_sel);

    p_full_stop_sets_r4: assert property (@(posedge clk) disable iff (rst)
        (stop_req && !in_stop && !rd_data[1]) |=> sys_clk_sel);

    p_restart_from_write_r7: assert property (@(posedge clk) disable iff (rst)
        wd_restart |-> $past(wr_en));

    p_src_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(rd_data[3]));

    p_timer_gate_r9: assert property (@(posedge clk) disable iff (rst)
        (in_stop && !rd_data[5]) |-> !tmr_clk_en);

    p_stop_entry_r12: assert property (@(posedge clk) disable iff (rst)
        (stop_req && !in_stop) |=> in_stop);

endmodule

bind clkstop_ctl clkstop_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .osc_up      (osc_up),
    .stop_req    (stop_req),
    .wr_en       (wr_en),
    .rd_data     (rd_data),
    .sys_clk_sel (sys_clk_sel),
    .tmr_clk_en  (tmr_clk_en),
    .wd_restart  (wd_restart),
    .in_stop     (in_stop)
);

// File: tb/clkstop_ctl_bench.sv
`timescale 1ns/1ps
module clkstop_ctl_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       osc_up = 1'b1;
    logic       stop_req = 1'b0;
    logic       stop_exit = 1'b0;
    logic       slow_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       sys_clk_sel, osc_run, tmr_clk_en, wd_clk_en, wd_restart;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    clkstop_ctl u_clkstop_ctl (
        .clk(clk), .rst(rst), .osc_up(osc_up), .stop_req(stop_req),
        .stop_exit(stop_exit), .slow_tick(slow_tick), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .sys_clk_sel(sys_clk_sel),
        .osc_run(osc_run), .tmr_clk_en(tmr_clk_en), .wd_clk_en(wd_clk_en),
        .wd_restart(wd_restart)
    );

    // Stop-mode vectors: {write value, osc_run, tmr_clk_en, wd_clk_en in stop}
    localparam logic [10:0] VEC [8] = '{
        {8'h01, 3'b000},
        {8'h23, 3'b100},
        {8'hA3, 3'b110},
        {8'h53, 3'b101},
        {8'hF3, 3'b111},
        {8'hF1, 3'b000},
        {8'h43, 3'b100},
        {8'h83, 3'b100}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] v);
        wr_en = 1'b1;
        wr_data = v;
        step();
        wr_en = 1'b0;
    endtask

    task automatic enter_stop();
        stop_req = 1'b1;
        step();
        stop_req = 1'b0;
    endtask

    task automatic leave_stop();
        stop_exit = 1'b1;
        step();
        stop_exit = 1'b0;
    endtask

    task automatic tick();
        slow_tick = 1'b1;
        step();
        slow_tick = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk + 1 - n_bad, n_chk + 1);
        $finish;
    end

    initial begin
        @(negedge clk);
        repeat (3) step();
        rst = 1'b0;
        // R1 reset state
        chk("R1 rd_data", rd_data, 8'h01);
        chk("R1 sys_clk_sel", 8'(sys_clk_sel), 8'h1);
        chk("R1 osc_run", 8'(osc_run), 8'h1);
        chk("R1 tmr_clk_en", 8'(tmr_clk_en), 8'h1);
        chk("R1 wd_clk_en", 8'(wd_clk_en), 8'h1);
        chk("R1 wd_restart", 8'(wd_restart), 8'h0);

        // R9 R10 R6 R12: stop-mode vector walk
        for (int i = 0; i < 8; i++) begin
            wr(VEC[i][10:3]);
            step();
            enter_stop();
            chk("R6 osc_run in stop", 8'(osc_run), 8'(VEC[i][2]));
            chk("R9 tmr_clk_en in stop", 8'(tmr_clk_en), 8'(VEC[i][1]));
            chk("R10 wd_clk_en in stop", 8'(wd_clk_en), 8'(VEC[i][0]));
            leave_stop();
            chk("R12 osc_run after exit", 8'(osc_run), 8'h1);
            chk("R9 tmr_clk_en after exit", 8'(tmr_clk_en), 8'h1);
        end

        // R2 R5: clear PLL select with oscillator up
        wr(8'h00);
        chk("R2 clear accepted", rd_data, 8'h00);
        chk("R5 sys_clk_sel osc", 8'(sys_clk_sel), 8'h0);
        chk("R7 no pulse without change", 8'(wd_restart), 8'h0);

        // R3: oscillator down forces PLL select
        osc_up = 1'b0;
        step();
        chk("R3 forced pll_sel", rd_data, 8'h01);
        chk("R5 sys_clk_sel pll", 8'(sys_clk_sel), 8'h1);

        // R2 R8 R7: write while oscillator down
        wr(8'h08);
        chk("R2 clear ignored, R8 src1 set", rd_data, 8'h09);
        chk("R7 pulse on src1 change", 8'(wd_restart), 8'h1);
        step();
        chk("R7 pulse one cycle", 8'(wd_restart), 8'h0);

        osc_up = 1'b1;
        wr(8'h08);
        chk("R2 clear with osc up", rd_data, 8'h08);
        osc_up = 1'b0;
        step();
        chk("R8 src1 kept when osc drops", rd_data, 8'h09);
        osc_up = 1'b1;

        // R7 source-change rules
        wr(8'h18);
        chk("R7 src0 ignored under src1", 8'(wd_restart), 8'h0);
        chk("R7 rd after src0 write", rd_data, 8'h18);
        wr(8'h10);
        chk("R7 pulse src1 cleared", 8'(wd_restart), 8'h1);
        wr(8'h00);
        chk("R7 pulse src0 change", 8'(wd_restart), 8'h1);

        // R4: full stop entry sets PLL select
        enter_stop();
        chk("R4 full stop sets pll_sel", rd_data, 8'h01);
        chk("R6 osc off in full stop", 8'(osc_run), 8'h0);
        leave_stop();

        // R6: pseudo stop keeps oscillator, PLL select untouched
        wr(8'h02);
        enter_stop();
        chk("R4 pseudo stop keeps bit0", rd_data, 8'h02);
        chk("R6 osc runs in pseudo stop", 8'(osc_run), 8'h1);
        // R12: second request while in stop ignored
        enter_stop();
        chk("R12 repeated request", 8'(osc_run), 8'h1);
        leave_stop();

        // R11: RC watchdog gate through synchronizer
        wr(8'h0E);
        enter_stop();
        chk("R11 wd on at entry", 8'(wd_clk_en), 8'h1);
        tick();
        chk("R11 wd on after 1 tick", 8'(wd_clk_en), 8'h1);
        tick();
        chk("R11 wd off after 2 ticks", 8'(wd_clk_en), 8'h0);
        leave_stop();
        chk("R11 wd still off at exit", 8'(wd_clk_en), 8'h0);
        tick();
        chk("R11 wd off 1 tick after exit", 8'(wd_clk_en), 8'h0);
        tick();
        chk("R11 wd on 2 ticks after exit", 8'(wd_clk_en), 8'h1);

        // R11: gate bit clear keeps RC watchdog clock
        wr(8'h0A);
        enter_stop();
        tick();
        tick();
        chk("R11 wd kept with gate clear", 8'(wd_clk_en), 8'h1);
        leave_stop();

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule